// File: doc/BRIEF.md
# Six-Pin Parallel I/O Port with Mismatch Interrupt

This block is a six-pin general-purpose parallel port behind a small register interface. Software chooses a direction for each pin and sets the level of every pin that drives. It can also sample the levels present on the pins. Pin inputs pass through a two-flop synchroniser before any other logic uses them.

A compare register holds the expected pin pattern. A mask register selects which pins take part in the comparison. The interrupt output is a plain level: it is high while at least one selected pin differs from its expected value. It is not latched, so it falls as soon as the last selected mismatch clears.

The bus side is a single-cycle request port. A request with write enable high updates a register on that clock edge. A request with write enable low returns read data on the next cycle.

Top module: `gpio_cmp_port`

## Requirements
- R1: After reset the output, compare, mask and direction registers are all zero, `pin_oe_o`, `pin_o`, `irq_o` and `rdata_o` are zero, and every readable register reads back as zero.
- R2: The direction register at byte offset 0x30 is read/write. Bit n set to 1 makes pin n an output (`pin_oe_o[n]` = 1); bit n at 0 makes it an input.
- R3: The output data register at offset 0x00 is read/write. `pin_o[n]` carries its bit n when direction bit n is 1 and is 0 otherwise. The stored value reads back in full, whatever the direction setting.
- R4: The input register at offset 0x10 returns, in bits 5:0, the synchronised pin levels present in the cycle of the read request. A pin level held for at least two clock cycles before the request is returned exactly.
- R5: Read data appears on `rdata_o` in the cycle after a read request and is zero in every other cycle. Bits 31:6 are always zero, and a read of any offset other than 0x00, 0x10, 0x20, 0x28 or 0x30 returns zero.
- R6: A write to the input register offset 0x10 changes no register and no output.
- R7: The compare register at offset 0x20 and the mask register at offset 0x28 are read/write, each holding bits 5:0.
- R8: `irq_o` is 1 exactly when some bit n has mask bit n = 1 and synchronised pin n different from compare bit n. It is a level and is not held once that condition ends.
- R9: A pin change reaches `irq_o` two clock edges after it appears on `pin_i`, because of the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request valid for one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| pin_i | input | 6 | Pin levels from the pads, asynchronous |
| pin_o | output | 6 | Pin output levels |
| pin_oe_o | output | 6 | Pin output enables |
| irq_o | output | 1 | Level interrupt on a masked compare mismatch |

## Verification
The assertions assume that the bus inputs are stable across each rising clock edge. They also assume that a request lasts for a single cycle in which both `req_i` and `we_i` are known. The bench meets this by changing every input only on falling edges and by keeping `req_i` low throughout reset. Pin inputs change at arbitrary falling edges, because the comparator sees them only after synchronisation. The directed phases hold pins steady for at least two cycles before a sample is required, and the random phase is judged against a model that tracks the same two-cycle delay.

// File: rtl/gpio_cmp_pkg.sv
`timescale 1ns/1ps
package gpio_cmp_pkg;
  localparam int unsigned OFF_OUT  = 32'h00;
  localparam int unsigned OFF_IN   = 32'h10;
  localparam int unsigned OFF_CMP  = 32'h20;
  localparam int unsigned OFF_MASK = 32'h28;
  localparam int unsigned OFF_DIR  = 32'h30;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_OUT, SEL_IN, SEL_CMP, SEL_MASK, SEL_DIR
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] ff_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[0] <= '0;
        else         ff_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[s] <= '0;
        else         ff_q[s] <= ff_q[s-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/gpio_cmp.sv
`timescale 1ns/1ps
module gpio_cmp #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] cmp_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic             irq_o
);
  logic [WIDTH-1:0] miss;

  assign miss  = (pin_i ^ cmp_i) & mask_i;
  assign irq_o = |miss;

  // R8
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !irq_o);

  // R8
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_i == cmp_i) |-> !irq_o);
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
  import gpio_cmp_pkg::*;
#(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [WIDTH-1:0]  pin_sync_i,
  output logic [WIDTH-1:0]  out_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  cmp_o,
  output logic [WIDTH-1:0]  mask_o
);
  reg_sel_e          sel;
  logic [WIDTH-1:0]  out_q, dir_q, cmp_q, mask_q;
  logic [WIDTH-1:0]  rd_val;
  logic [DATA_W-1:0] rdata_q;
  logic              wr_en, rd_en;

  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFF_OUT):  sel = SEL_OUT;
      ADDR_W'(OFF_IN):   sel = SEL_IN;
      ADDR_W'(OFF_CMP):  sel = SEL_CMP;
      ADDR_W'(OFF_MASK): sel = SEL_MASK;
      ADDR_W'(OFF_DIR):  sel = SEL_DIR;
      default:           sel = SEL_NONE;
    endcase
  end

  assign wr_en = req_i & we_i;
  assign rd_en = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      cmp_q  <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      unique case (sel)
        SEL_OUT:  out_q  <= wdata_i[WIDTH-1:0];
        SEL_CMP:  cmp_q  <= wdata_i[WIDTH-1:0];
        SEL_MASK: mask_q <= wdata_i[WIDTH-1:0];
        SEL_DIR:  dir_q  <= wdata_i[WIDTH-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      SEL_OUT:  rd_val = out_q;
      SEL_IN:   rd_val = pin_sync_i;
      SEL_CMP:  rd_val = cmp_q;
      SEL_MASK: rd_val = mask_q;
      SEL_DIR:  rd_val = dir_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= DATA_W'(rd_val);
    else            rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
  assign out_o   = out_q;
  assign dir_o   = dir_q;
  assign cmp_o   = cmp_q;
  assign mask_o  = mask_q;

  // R1
  reset_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (out_q == '0 && dir_q == '0 && cmp_q == '0 && mask_q == '0));

  // R5
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_en) |-> (rdata_o == '0));

  // R6
  ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && sel == SEL_IN) |=>
      ($stable(out_q) && $stable(dir_q) && $stable(cmp_q) && $stable(mask_q)));
endmodule

// File: rtl/gpio_cmp_port.sv
`timescale 1ns/1ps
module gpio_cmp_port #(
  parameter int unsigned WIDTH       = 6,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o,
  output logic              irq_o
);
  logic [WIDTH-1:0] pin_sync, out_val, dir_val, cmp_val, mask_val;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .pin_sync_i(pin_sync),
    .out_o     (out_val),
    .dir_o     (dir_val),
    .cmp_o     (cmp_val),
    .mask_o    (mask_val)
  );

  gpio_cmp #(.WIDTH(WIDTH)) u_cmp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_sync),
    .cmp_i (cmp_val),
    .mask_i(mask_val),
    .irq_o (irq_o)
  );

  assign pin_oe_o = dir_val;
  assign pin_o    = out_val & dir_val;

  // R3
  undriven_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o & ~pin_oe_o) == '0);
endmodule

// File: tb/gpio_cmp_port_tb_top.sv
`timescale 1ns/1ps
module gpio_cmp_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  pin = '0;
  logic [5:0]  pin_o, pin_oe;
  logic        irq;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_cmp_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .pin_o(pin_o),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // behavioural reference
  logic [5:0]  m_out, m_dir, m_cmp, m_mask;
  logic [5:0]  m_hist [$];
  logic [31:0] m_rdata;

  function automatic logic [5:0] m_sync();
    return m_hist[0];
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00:   return {26'd0, m_out};
      8'h10:   return {26'd0, m_sync()};
      8'h20:   return {26'd0, m_cmp};
      8'h28:   return {26'd0, m_mask};
      8'h30:   return {26'd0, m_dir};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = '0; m_dir = '0; m_cmp = '0; m_mask = '0; m_rdata = '0;
      m_hist = '{6'd0, 6'd0};
    end else begin
      m_rdata = (req && !we) ? m_read(addr) : 32'd0;
      if (req && we) begin
        case (addr)
          8'h00: m_out  = wdata[5:0];
          8'h20: m_cmp  = wdata[5:0];
          8'h28: m_mask = wdata[5:0];
          8'h30: m_dir  = wdata[5:0];
          default: ;
        endcase
      end
      void'(m_hist.pop_front());
      m_hist.push_back(pin);
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(pin_oe == m_dir, "R2", 32'(pin_oe), 32'(m_dir));
      chk(pin_o == (m_out & m_dir), "R3", 32'(pin_o), 32'(m_out & m_dir));
      chk(irq == (|((m_sync() ^ m_cmp) & m_mask)), "R8", 32'(irq),
          32'(|((m_sync() ^ m_cmp) & m_mask)));
      chk(rdata == m_rdata, "R5", rdata, m_rdata);
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs in reset
    chk(pin_oe == 0 && pin_o == 0 && irq == 0 && rdata == 0, "R1",
        {pin_oe, pin_o, 3'd0, irq, 16'd0}, 32'd0);
    rst_n = 1'b1;
    rd(8'h00, 0, "R1"); rd(8'h20, 0, "R1"); rd(8'h28, 0, "R1"); rd(8'h30, 0, "R1");

    // direction and output drive
    wr(8'h30, 32'hFFFF_FF2A);
    chk(pin_oe == 6'h2A, "R2", 32'(pin_oe), 32'h2A);
    wr(8'h00, 32'h0000_003F);
    chk(pin_o == 6'h2A, "R3", 32'(pin_o), 32'h2A);
    rd(8'h30, 32'h2A, "R2");
    rd(8'h00, 32'h3F, "R3");

    // input sampling
    pin = 6'h15;
    repeat (2) @(negedge clk);
    rd(8'h10, 32'h15, "R4");

    // write to input register ignored
    wr(8'h10, 32'h3F);
    rd(8'h10, 32'h15, "R6");
    rd(8'h00, 32'h3F, "R6");
    rd(8'h30, 32'h2A, "R6");

    // unmapped reads
    rd(8'h08, 0, "R5"); rd(8'h3C, 0, "R5"); rd(8'hFF, 0, "R5");

    // compare / mask
    wr(8'h20, 32'h15); wr(8'h28, 32'h3F);
    rd(8'h20, 32'h15, "R7"); rd(8'h28, 32'h3F, "R7");
    chk(irq == 0, "R8", 32'(irq), 0);

    // pin change latency to irq
    @(negedge clk); pin = 6'h14;
    @(negedge clk); chk(irq == 0, "R9", 32'(irq), 0);
    @(negedge clk); chk(irq == 1, "R9", 32'(irq), 1);
    wr(8'h28, 32'h3E);
    chk(irq == 0, "R8", 32'(irq), 0);
    wr(8'h28, 32'h3F);
    chk(irq == 1, "R8", 32'(irq), 1);
    pin = 6'h15;
    repeat (2) @(negedge clk);
    chk(irq == 0, "R8", 32'(irq), 0);

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      req = ($urandom_range(0, 2) != 0);
      we  = $urandom_range(0, 1) == 1;
      case ($urandom_range(0, 6))
        0: addr = 8'h00; 1: addr = 8'h10; 2: addr = 8'h20;
        3: addr = 8'h28; 4: addr = 8'h30; 5: addr = 8'h04;
        default: addr = 8'h2C;
      endcase
      wdata = $urandom();
      if ($urandom_range(0, 3) == 0) pin = 6'($urandom());
    end
    @(negedge clk); req = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule